// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a short memory burst. An address strobe captures a 16-bit start address on a rising clock edge. The address comes from either the processor-side strobe or the controller-side strobe. After that, an advance input steps a 2-bit burst count. The two low address bits are recomputed from the captured start bits and the count. The upper bits keep the captured value for the whole burst.

An order-select input picks one of two sequences:

- **Interleaved (order_sel = 0):** the low bits are the start bits XOR the count.
- **Linear (order_sel = 1):** the low bits are the start bits plus the count, modulo four.

The order is captured together with the start address, so one burst keeps one ordering from start to end. The processor-side strobe only counts while the chip is selected. The controller-side strobe is always accepted.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset is released, eff_addr is 0.
- R2: A load occurs when ctl_strobe is 1, or when cpu_strobe and chip_sel are both 1, at a rising clock edge. After that edge, eff_addr equals the sampled addr_in, and the burst count is 0.
- R3: cpu_strobe sampled while chip_sel is 0 causes no load. With no advance in the same cycle, eff_addr is unchanged after that edge.
- R4: ctl_strobe causes a load whatever the value of chip_sel.
- R5: advance at an edge without a load adds one to the burst count. An edge with neither a load nor advance leaves eff_addr unchanged.
- R6: Between loads, eff_addr[15:2] holds the value captured at the last load.
- R7: With the captured order 0 (interleaved), eff_addr[1:0] equals the captured start bits XOR the burst count.
- R8: With the captured order 1 (linear), eff_addr[1:0] equals (captured start bits + burst count) mod 4.
- R9: The burst count wraps from 3 to 0 on the next advance. The fifth word of a burst is therefore the starting word again.
- R10: When a load and advance occur at the same edge, the load wins and the count becomes 0.
- R11: order_sel is sampled only at a load. Changing it during a burst leaves the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip selected; qualifies cpu_strobe |
| cpu_strobe | input | 1 | Processor-side address strobe |
| ctl_strobe | input | 1 | Controller-side address strobe, always accepted |
| advance | input | 1 | Step the burst count |
| order_sel | input | 1 | 0 = interleaved, 1 = linear; captured on load |
| addr_in | input | 16 | Start address |
| eff_addr | output | 16 | Effective word address |

## Verification
The assertions check the following on every cycle:

- Loading from either strobe.
- Rejection of a deselected processor strobe.
- Holding when idle.
- Stability of the upper bits between loads.
- The count step and its wrap.
- Load priority over advance.

The low-bit orderings of R7 and R8 can only be shown by the bench's scenarios. So can the frozen order of R11. These scenarios walk bursts from every start offset in both modes, with extra advances past the fourth word and order_sel toggled mid-burst. The bench's reference model checks each address against the expected sequence.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;
endpackage

// File: rtl/bag_strobe_gate.sv
module bag_strobe_gate (
  input  logic chip_sel,
  input  logic cpu_strobe,
  input  logic ctl_strobe,
  input  logic advance,
  output logic load_evt,
  output logic step_evt
);
  logic cpu_ok;

  always_comb begin
    cpu_ok   = cpu_strobe & chip_sel;
    load_evt = ctl_strobe | cpu_ok;
    step_evt = advance & ~load_evt;
  end
endmodule

// File: rtl/bag_start_reg.sv
module bag_start_reg
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  order_e            order_in,
  output logic [ADDR_W-1:CNT_W] base_hi,
  output logic [CNT_W-1:0]  start_low,
  output order_e            order_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= '0;
      start_low <= '0;
      order_q   <= ORD_INTERLEAVE;
    end else if (load) begin
      base_hi   <= addr_in[ADDR_W-1:CNT_W];
      start_low <= addr_in[CNT_W-1:0];
      order_q   <= order_in;
    end
  end
endmodule

// File: rtl/bag_burst_counter.sv
module bag_burst_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else if (step) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/bag_low_mux.sv
module bag_low_mux
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_low,
  input  logic [CNT_W-1:0] cnt,
  input  order_e           order,
  output logic [CNT_W-1:0] low
);
  function automatic logic [CNT_W-1:0] seq_interleave(
    input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] c);
    return s ^ c;
  endfunction

  function automatic logic [CNT_W-1:0] seq_linear(
    input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] c);
    return s + c;
  endfunction

  logic [CNT_W-1:0] low_il;
  logic [CNT_W-1:0] low_ln;

  always_comb begin
    low_il = seq_interleave(start_low, cnt);
    low_ln = seq_linear(start_low, cnt);
    case (order)
      ORD_LINEAR: low = low_ln;
      default:    low = low_il;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              cpu_strobe,
  input  logic              ctl_strobe,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr
);
  logic                    load_evt;
  logic                    step_evt;
  logic [CNT_W-1:0]        burst_cnt;
  logic [CNT_W-1:0]        start_low;
  logic [CNT_W-1:0]        low_bits;
  logic [ADDR_W-1:CNT_W]   base_hi;
  order_e                  order_in;
  order_e                  order_q;

  assign order_in = order_e'(order_sel);

  bag_strobe_gate u_gate (
    .chip_sel  (chip_sel),
    .cpu_strobe(cpu_strobe),
    .ctl_strobe(ctl_strobe),
    .advance   (advance),
    .load_evt  (load_evt),
    .step_evt  (step_evt)
  );

  bag_start_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .addr_in  (addr_in),
    .order_in (order_in),
    .base_hi  (base_hi),
    .start_low(start_low),
    .order_q  (order_q)
  );

  bag_burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_evt),
    .step (step_evt),
    .cnt  (burst_cnt)
  );

  bag_low_mux #(.CNT_W(CNT_W)) u_low (
    .start_low(start_low),
    .cnt      (burst_cnt),
    .order    (order_q),
    .low      (low_bits)
  );

  assign eff_addr = {base_hi, low_bits};
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sel,
  input logic              cpu_strobe,
  input logic              ctl_strobe,
  input logic              advance,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              load_evt,
  input logic [CNT_W-1:0]  burst_cnt
);
  // R2 / R4: an accepted strobe captures the input address with count zero
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_strobe || (cpu_strobe && chip_sel)) |=>
      (eff_addr == $past(addr_in) && burst_cnt == '0));

  // R3: deselected processor strobe does nothing
  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe && !chip_sel && !ctl_strobe && !advance) |=> $stable(eff_addr));

  // R5: idle edges keep the address
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe && !(cpu_strobe && chip_sel) && !advance) |=> $stable(eff_addr));

  // R6: upper bits hold between loads
  p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(eff_addr[ADDR_W-1:CNT_W]));

  // R9: advance steps the count modulo the burst length
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_evt) |=> burst_cnt == CNT_W'($past(burst_cnt) + CNT_W'(1)));

  // R10: load beats advance
  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ctl_strobe) |=> burst_cnt == '0);
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_sel  (chip_sel),
  .cpu_strobe(cpu_strobe),
  .ctl_strobe(ctl_strobe),
  .advance   (advance),
  .addr_in   (addr_in),
  .eff_addr  (eff_addr),
  .load_evt  (load_evt),
  .burst_cnt (burst_cnt)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel = 1'b0;
  logic        cpu_strobe = 1'b0;
  logic        ctl_strobe = 1'b0;
  logic        advance = 1'b0;
  logic        order_sel = 1'b0;
  logic [15:0] addr_in = '0;
  logic [15:0] eff_addr;

  int tests = 0;
  int fails = 0;

  // reference model state
  int m_base = 0;
  int m_cnt  = 0;
  int m_lin  = 0;

  always #5 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .cpu_strobe(cpu_strobe),
    .ctl_strobe(ctl_strobe), .advance(advance), .order_sel(order_sel),
    .addr_in(addr_in), .eff_addr(eff_addr)
  );

  function automatic int expect_addr();
    int s, lo;
    s = m_base % 4;
    if (m_lin != 0) lo = (s + m_cnt) % 4;
    else            lo = s ^ m_cnt;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string tag);
    int e;
    e = expect_addr();
    tests++;
    if (int'(eff_addr) != e) begin
      fails++;
      $display("FAIL %s: eff_addr=%h expected=%h", tag, eff_addr, e[15:0]);
    end
  endtask

  // drive at negedge, model on posedge, compare at next negedge
  task automatic tick(input logic cs, input logic ps, input logic cs2,
                      input logic adv, input logic md, input int a,
                      input string tag);
    chip_sel = cs; cpu_strobe = ps; ctl_strobe = cs2;
    advance = adv; order_sel = md; addr_in = a[15:0];
    @(posedge clk);
    if (cs2 || (ps && cs)) begin
      m_base = a; m_cnt = 0; m_lin = md;
    end else if (adv) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // interleaved and linear bursts from every start offset, with wrap
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        tick(1, 1, 0, 0, md[0], 16'hA5F0 + s + md * 16'h0100, "R2 cpu load");
        for (int k = 0; k < 6; k++)
          tick(0, 0, 0, 1, ~md[0], 0,
               md == 0 ? "R7 R9 R11 interleaved step" : "R8 R9 R11 linear step");
      end
    end

    // deselected processor strobe ignored
    tick(0, 0, 1, 0, 0, 16'h1232, "R4 ctl load deselected");
    tick(0, 0, 0, 1, 0, 0, "R5 step");
    tick(0, 1, 0, 0, 1, 16'hFFFF, "R3 cpu strobe ignored");
    tick(0, 0, 0, 0, 1, 16'h0000, "R5 idle hold");
    tick(0, 0, 0, 1, 0, 0, "R6 R7 upper held");

    // load and advance together
    tick(1, 0, 1, 1, 1, 16'h7FFE, "R10 ctl beats advance");
    tick(1, 0, 0, 1, 0, 0, "R8 linear after priority");
    tick(1, 1, 0, 1, 0, 16'h0003, "R10 cpu beats advance");
    tick(1, 0, 0, 1, 1, 0, "R7 R11 interleaved step");
    tick(1, 0, 0, 1, 1, 0, "R7 R11 interleaved step");
    tick(0, 1, 0, 1, 1, 16'h4444, "R3 deselected strobe with advance");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule